// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural register values of a dynamically scheduled pipeline. Beside each value it keeps a small tag that names the reservation station that will write that register next. A tag of zero means that no write is pending. When an instruction issues, the block resolves its two source registers. A source with no pending writer yields its stored value. A source with a pending writer yields that writer's tag, and the station then waits for that tag on the result bus. In the same cycle, the issuing station's tag becomes the destination register's new pending writer.

The block snoops the common result bus. A broadcast updates a register only when the broadcast tag equals the writer that register currently records. If a register has since been renamed to a younger writer, the result of the older writer is dropped. This removes write-after-write and write-after-read hazards without stalling issue. Reservation stations and functional units are outside this block.

Top module: `rename_status_table`

## Requirements
- R1: Synchronous active-high reset sets every register value to zero and clears every pending-writer tag. After reset, every source lookup reports ready with value 0.
- R2: A source lookup of a register with no pending writer drives ready=1, the register's value, and tag 0.
- R3: A source lookup of a register with a pending writer, when no matching broadcast is present, drives ready=0 and that writer's tag.
- R4: An issue with a nonzero station tag records that tag as the destination register's pending writer. The record is visible to lookups from the next cycle on.
- R5: A later issue to the same destination replaces the recorded writer, even while the older writer is still outstanding.
- R6: A broadcast whose nonzero tag equals a register's recorded writer loads the broadcast value into that register and clears its pending tag. The effect is visible from the next cycle.
- R7: A broadcast from a writer that has since been replaced leaves the register's pending tag unchanged, and it does not make the register ready.
- R8: When a source's pending writer is broadcasting in the same cycle as the lookup, the lookup drives ready=1 with the bus value.
- R9: When an issuing instruction names its destination as a source, the source lookup uses the state from before this issue's destination update.
- R10: When an issue to a register and the broadcast of that register's current writer happen in the same cycle, the new writer's tag stays pending.
- R11: A broadcast carrying tag 0 changes no register.
- R12: One broadcast updates every register whose recorded writer equals the broadcast tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | IDX_W | First source register index |
| iss_src_b | input | IDX_W | Second source register index |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Tag of the issuing station (nonzero) |
| bus_valid | input | 1 | A result is on the common bus |
| bus_tag | input | TAG_W | Tag of the station broadcasting |
| bus_data | input | DATA_W | Broadcast result value |
| opa_ready | output | 1 | First operand is a value |
| opa_value | output | DATA_W | First operand value |
| opa_tag | output | TAG_W | First operand pending writer (0 when ready) |
| opb_ready | output | 1 | Second operand is a value |
| opb_value | output | DATA_W | Second operand value |
| opb_tag | output | TAG_W | Second operand pending writer (0 when ready) |

## Verification
The bench builds the block with eight registers, 16-bit values and 3-bit tags. With these sizes, the reset check sweeps every register and every station tag, including the largest value 7, is used in a test. The narrower values keep the expected results easy to read. The same sizes still reach the ordering cases: a stale broadcast after a rename, a same-cycle bypass, a self-referencing issue, an issue colliding with a broadcast, and a tag shared by two registers.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int DEF_REGS   = 32;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_TAG_W  = 4;

    typedef enum logic {
        OPND_WAIT  = 1'b0,
        OPND_VALUE = 1'b1
    } opnd_kind_e;

    function automatic logic tag_hit(input logic valid, input int unsigned bus_t,
                                     input int unsigned held_t);
        return valid && (bus_t != 0) && (bus_t == held_t);
    endfunction

endpackage

// File: rtl/rrs_tag_table.sv
module rrs_tag_table
    import rrs_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             iss_valid,
    input  logic [IDX_W-1:0]                 iss_dst,
    input  logic [TAG_W-1:0]                 iss_tag,
    input  logic                             bus_valid,
    input  logic [TAG_W-1:0]                 bus_tag,
    output logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q,
    output logic [NUM_REGS-1:0]              bus_hit
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        logic renamed;
        assign renamed    = iss_valid && (iss_dst == IDX_W'(i));
        assign bus_hit[i] = tag_hit(bus_valid, int'(bus_tag), int'(tag_q[i]));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
            end else if (renamed) begin
                tag_q[i] <= iss_tag;
            end else if (bus_hit[i]) begin
                tag_q[i] <= '0;
            end
        end
    end

endmodule

// File: rtl/rrs_value_file.sv
module rrs_value_file
    import rrs_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int DATA_W   = DEF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              wr_en,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  val_q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[i] <= '0;
            end else if (wr_en[i]) begin
                val_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/rrs_src_lookup.sv
module rrs_src_lookup
    import rrs_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]                 src,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_q,
    input  logic                             bus_valid,
    input  logic [TAG_W-1:0]                 bus_tag,
    input  logic [DATA_W-1:0]                bus_data,
    output logic                             ready,
    output logic [DATA_W-1:0]                value,
    output logic [TAG_W-1:0]                 tag
);

    logic [TAG_W-1:0] writer;
    opnd_kind_e       kind;

    always_comb begin
        writer = tag_q[src];
        kind   = OPND_VALUE;
        value  = val_q[src];
        tag    = '0;
        if (writer != '0) begin
            if (tag_hit(bus_valid, int'(bus_tag), int'(writer))) begin
                value = bus_data;
            end else begin
                kind  = OPND_WAIT;
                value = '0;
                tag   = writer;
            end
        end
        ready = (kind == OPND_VALUE);
    end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
    import rrs_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              opa_ready,
    output logic [DATA_W-1:0] opa_value,
    output logic [TAG_W-1:0]  opa_tag,
    output logic              opb_ready,
    output logic [DATA_W-1:0] opb_value,
    output logic [TAG_W-1:0]  opb_tag
);

    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
    logic [NUM_REGS-1:0]             bus_hit;

    rrs_tag_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag),
        .tag_q(tag_q), .bus_hit(bus_hit)
    );

    rrs_value_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_vals (
        .clk(clk), .rst(rst),
        .wr_en(bus_hit), .wr_data(bus_data),
        .val_q(val_q)
    );

    rrs_src_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_a (
        .src(iss_src_a), .tag_q(tag_q), .val_q(val_q),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .ready(opa_ready), .value(opa_value), .tag(opa_tag)
    );

    rrs_src_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_b (
        .src(iss_src_b), .tag_q(tag_q), .val_q(val_q),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .ready(opb_ready), .value(opb_value), .tag(opb_tag)
    );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            iss_valid,
    input logic [IDX_W-1:0]                iss_dst,
    input logic [TAG_W-1:0]                iss_tag,
    input logic                            bus_valid,
    input logic [TAG_W-1:0]                bus_tag,
    input logic                            opa_ready,
    input logic [TAG_W-1:0]                opa_tag,
    input logic                            opb_ready,
    input logic [TAG_W-1:0]                opb_tag,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q
);

    // R1: the cycle after reset no register has a pending writer
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (tag_q == '0));

    // R2: a ready operand never carries a tag
    p_ready_no_tag_r2: assert property (@(posedge clk) disable iff (rst)
        opa_ready |-> (opa_tag == '0));

    // R3: a waiting operand always names a real writer
    p_wait_has_tag_r3: assert property (@(posedge clk) disable iff (rst)
        !opb_ready |-> (opb_tag != '0));

    // R4: the issuing tag is recorded for the destination one cycle later
    p_issue_records_r4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> (tag_q[$past(iss_dst)] == $past(iss_tag)));

    // R8: an operand never waits on the tag being broadcast right now
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_tag != '0 && !opa_ready) |-> (opa_tag != bus_tag));

endmodule

bind rename_status_table rrs_checker #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_rrs_checker (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag),
    .opa_ready(opa_ready), .opa_tag(opa_tag),
    .opb_ready(opb_ready), .opb_tag(opb_tag),
    .tag_q(tag_q)
);

// File: tb/rename_status_table_test.sv
`timescale 1ns/1ps
module rename_status_table_test;

    localparam int NR = 8;
    localparam int DW = 16;
    localparam int TW = 3;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid;
    logic [IW-1:0] iss_src_a, iss_src_b, iss_dst;
    logic [TW-1:0] iss_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_data;
    logic          opa_ready, opb_ready;
    logic [DW-1:0] opa_value, opb_value;
    logic [TW-1:0] opa_tag, opb_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rename_status_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .opa_ready(opa_ready), .opa_value(opa_value), .opa_tag(opa_tag),
        .opb_ready(opb_ready), .opb_value(opb_value), .opb_tag(opb_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_src_a = '0; iss_src_b = '0; iss_dst = '0; iss_tag = '0;
        bus_valid = 1'b0; bus_tag = '0; bus_data = '0;
    endtask

    task automatic issue(input int dst, input int tag);
        @(negedge clk);
        idle();
        iss_valid = 1'b1; iss_dst = IW'(dst); iss_tag = TW'(tag);
        @(negedge clk);
        idle();
    endtask

    task automatic bcast(input int tag, input int data);
        @(negedge clk);
        idle();
        bus_valid = 1'b1; bus_tag = TW'(tag); bus_data = DW'(data);
        @(negedge clk);
        idle();
    endtask

    task automatic look(input int a, input int b);
        @(negedge clk);
        idle();
        iss_src_a = IW'(a); iss_src_b = IW'(b);
        #1;
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) begin
            look(r, NR - 1 - r);
            check("R1 ready", int'(opa_ready), 1);
            check("R1 value", int'(opa_value), 0);
            check("R1 tag b", int'(opb_tag), 0);
        end
    endtask

    task automatic t_issue_wait();
        issue(2, 3);
        look(2, 4);
        check("R3 ready a", int'(opa_ready), 0);
        check("R3 tag a", int'(opa_tag), 3);
        check("R4 recorded", int'(opa_tag), 3);
        check("R2 ready b", int'(opb_ready), 1);
        check("R2 value b", int'(opb_value), 0);
    endtask

    task automatic t_broadcast();
        bcast(3, 16'h1234);
        look(4, 2);
        check("R6 ready b", int'(opb_ready), 1);
        check("R6 value b", int'(opb_value), 16'h1234);
        check("R6 tag b", int'(opb_tag), 0);
    endtask

    task automatic t_rename();
        issue(5, 1);
        issue(5, 2);
        look(5, 0);
        check("R5 tag", int'(opa_tag), 2);
        bcast(1, 16'hAAAA);
        look(5, 5);
        check("R7 stale ready", int'(opa_ready), 0);
        check("R7 stale tag", int'(opb_tag), 2);
        bcast(2, 16'hBBBB);
        look(5, 0);
        check("R5 young value", int'(opa_value), 16'hBBBB);
    endtask

    task automatic t_bypass();
        issue(6, 4);
        @(negedge clk);
        idle();
        iss_src_a = 3'd6; iss_src_b = 3'd6;
        bus_valid = 1'b1; bus_tag = 3'd4; bus_data = 16'h5555;
        #1;
        check("R8 ready", int'(opa_ready), 1);
        check("R8 value", int'(opb_value), 16'h5555);
        @(negedge clk);
        idle();
    endtask

    task automatic t_self_dep();
        @(negedge clk);
        idle();
        iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 3'd5;
        iss_src_a = 3'd2; iss_src_b = 3'd2;
        #1;
        check("R9 ready", int'(opa_ready), 1);
        check("R9 value", int'(opb_value), 16'h1234);
        @(negedge clk);
        idle();
        look(2, 0);
        check("R9 then pending", int'(opa_tag), 5);
    endtask

    task automatic t_collision();
        @(negedge clk);
        idle();
        iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 3'd6;
        bus_valid = 1'b1; bus_tag = 3'd5; bus_data = 16'h7777;
        @(negedge clk);
        idle();
        look(2, 2);
        check("R10 ready", int'(opa_ready), 0);
        check("R10 tag", int'(opb_tag), 6);
    endtask

    task automatic t_zero_tag();
        bcast(0, 16'hFFFF);
        look(4, 3);
        check("R11 value a", int'(opa_value), 0);
        check("R11 value b", int'(opb_value), 0);
    endtask

    task automatic t_multi();
        issue(0, 7);
        issue(1, 7);
        bcast(7, 16'h0F0F);
        look(0, 1);
        check("R12 value a", int'(opa_value), 16'h0F0F);
        check("R12 value b", int'(opb_value), 16'h0F0F);
        check("R12 ready b", int'(opb_ready), 1);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_issue_wait();
        t_broadcast();
        t_rename();
        t_bypass();
        t_self_dep();
        t_collision();
        t_zero_tag();
        t_multi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule